// File: doc/BRIEF.md
# Dual-Width Scratchpad Local Store

This block is a software-managed on-chip memory that a vector core uses in place of a cache. One storage array, organised as 1024-bit rows, is reached through two ports of different widths. The core side loads and stores one 128-bit register value per access. The transfer side moves a whole 1024-bit row per access, on behalf of an engine that copies blocks between this store and main memory. There are no tags, no misses and no coherency tracking. The core reaches main memory only by staging data through this store.

A block request gives a store start address, a byte length and a direction. After checking the request, a sequencer turns it into one wide-row beat per cycle over consecutive rows. It wraps at the end of the store and pulses a completion flag once the last beat has gone. The transfer side always wins the array. While beats are running, the core port is held off with a ready/valid handshake.

Top module: `spad_local_store`

## Requirements
- R1: A core access accepted with `core_valid` and `core_ready` high, and with `core_addr[3:0]` equal to zero, reaches 128-bit lane `core_addr[6:4]` of row `core_addr[ADDR_W-1:7]`. A write replaces only that lane. A read returns the lane on `core_rdata` with `core_rvalid` high in the cycle after acceptance.
- R2: A core access accepted while `core_addr[3:0]` is not zero raises `core_err` for exactly the next cycle. It writes nothing and produces no `core_rvalid`.
- R3: A block request accepted while `blk_ready` is high is rejected when its length is under 1024 or over 16384 bytes, or when its length or start address is not a multiple of 128. On rejection `blk_err` is high in the next cycle and no beat is issued.
- R4: A valid block request issues exactly length/128 beats on consecutive cycles. The first beat starts in the cycle after acceptance. Beat k uses row (start/128 + k) modulo the number of rows, so a block can wrap past the top of the store.
- R5: With `blk_to_store` high, each beat writes the full 1024-bit `xfer_wdata` present in that beat cycle into the row.
- R6: With `blk_to_store` low, each beat reads its row. The row contents appear on `xfer_rdata` with `xfer_rvalid` high in the cycle after the beat.
- R7: `blk_done` is high for exactly one cycle, the cycle right after the last beat. `blk_ready` is low from the cycle after acceptance until that cycle.
- R8: In every beat cycle `core_ready` is low and the core access waits. A core read held across a block write completes after the beats and returns the data the beats wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core access request |
| core_ready | output | 1 | Core access accepted this cycle when high |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Byte address in the store |
| core_wdata | input | 128 | Store data |
| core_rvalid | output | 1 | Load data valid |
| core_rdata | output | 128 | Load data |
| core_err | output | 1 | Misaligned core access flag |
| blk_valid | input | 1 | Block request |
| blk_ready | output | 1 | Sequencer idle, request can be taken |
| blk_to_store | input | 1 | 1 = main memory into store, 0 = store out to main memory |
| blk_addr | input | ADDR_W | Store start byte address |
| blk_len | input | LEN_W | Block length in bytes |
| blk_err | output | 1 | Request rejected |
| blk_done | output | 1 | Block finished pulse |
| xfer_beat | output | 1 | A wide beat uses the array this cycle |
| xfer_wdata | input | 1024 | Row data for an inbound beat |
| xfer_rvalid | output | 1 | Outbound row data valid |
| xfer_rdata | output | 1024 | Outbound row data |

## Verification
Core traffic mixes stores and loads over different lanes of the same row and of different rows. This separates correct lane selection and lane-only writes from whole-row corruption. Block traffic covers an inbound run in the middle of the store and a maximum-length inbound run that wraps around the store twice, where the second pass must overwrite the first. It also covers a short outbound run that wraps at the top. Each request at or just past a length or alignment limit shows whether the validity check sits on the exact boundary. A load issued during an inbound run must stall and then return the freshly written row, which tells real transfer priority apart from an access that slips in between beats.

// File: rtl/spad_pkg.sv
// Shared constants for the scratchpad local store.
// Assumes a 128-bit core lane and a 1024-bit array row.
package spad_pkg;
    localparam int NARROW_W   = 128;
    localparam int WIDE_W     = 1024;
    localparam int LANES      = WIDE_W / NARROW_W;
    localparam int LANE_SEL_W = $clog2(LANES);
    localparam int LANE_OFS   = $clog2(NARROW_W / 8);
    localparam int ROW_OFS    = $clog2(WIDE_W / 8);

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/spad_store_array.sv
// Single-ported storage of ROWS rows, each split into LANES banks of one core lane.
// Each bank takes its own write enable, so a core store touches one lane and a
// wide beat touches all of them. Reads return the contents from before the
// write, registered one cycle later. No reset on the contents.
module spad_store_array
    import spad_pkg::*;
#(
    parameter int ROWS  = 2048,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic [LANES-1:0]     lane_we,
    input  logic [ROW_W-1:0]     row,
    input  logic [WIDE_W-1:0]    wdata,
    output logic [WIDE_W-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [NARROW_W-1:0] bank [ROWS];
        logic [NARROW_W-1:0] rd_q;

        // Write the lane when enabled and capture the old contents for reading.
        always_ff @(posedge clk) begin
            if (en) begin
                if (lane_we[g]) bank[row] <= wdata[g*NARROW_W +: NARROW_W];
                rd_q <= bank[row];
            end
        end

        assign rdata[g*NARROW_W +: NARROW_W] = rd_q;
    end

    // A write hits either every lane (wide beat) or at most one lane (core store).
    always_comb begin
        if (en && lane_we != '1)
            assert_lane_write_onehot_R1: assert ($onehot0(lane_we));
    end
endmodule

// File: rtl/spad_port_arbiter.sv
// Chooses which port drives the shared array in each cycle. A wide beat always
// wins; a core request is granted only in a cycle with no beat. Also records
// which port issued a read, so the returning data goes to the right port.
module spad_port_arbiter
    import spad_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_req,
    input  logic                  xfer_we,
    input  logic [ROW_W-1:0]      xfer_row,
    input  logic [WIDE_W-1:0]     xfer_wdata,
    input  logic                  core_req,
    input  logic                  core_we,
    input  logic [ROW_W-1:0]      core_row,
    input  logic [LANE_SEL_W-1:0] core_lane,
    input  logic [NARROW_W-1:0]   core_wdata,
    output logic                  core_grant,
    output logic                  arr_en,
    output logic [LANES-1:0]      arr_lane_we,
    output logic [ROW_W-1:0]      arr_row,
    output logic [WIDE_W-1:0]     arr_wdata,
    output logic                  xfer_rd_q,
    output logic                  core_rd_q,
    output logic [LANE_SEL_W-1:0] core_lane_q
);
    assign core_grant = core_req && !xfer_req;

    // Steer address, data and lane enables from the winning port.
    always_comb begin
        arr_en      = xfer_req || core_grant;
        arr_row     = xfer_req ? xfer_row : core_row;
        arr_wdata   = xfer_req ? xfer_wdata : {LANES{core_wdata}};
        arr_lane_we = '0;
        if (xfer_req && xfer_we)
            arr_lane_we = '1;
        else if (core_grant && core_we)
            arr_lane_we = LANES'(1) << core_lane;
    end

    // Remember which port owns the read data returning next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_rd_q   <= 1'b0;
            core_rd_q   <= 1'b0;
            core_lane_q <= '0;
        end else begin
            xfer_rd_q   <= xfer_req && !xfer_we;
            core_rd_q   <= core_grant && !core_we;
            core_lane_q <= core_lane;
        end
    end

    // A core read result never shares a cycle with a wide read result.
    assert_single_reader_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_rd_q && core_rd_q));
endmodule

// File: rtl/spad_block_seq.sv
// Checks a block request and splits a valid one into wide-row beats, one per
// cycle, over consecutive rows that wrap modulo the row count. Assumes ROWS is
// a power of two and that the transfer side always wins the array.
module spad_block_seq
    import spad_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int LEN_W   = 15,
    parameter int MIN_BLK = 1024,
    parameter int MAX_BLK = 16384,
    localparam int ROW_W  = ADDR_W - ROW_OFS,
    localparam int CNT_W  = LEN_W - ROW_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_to_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic              req_err,
    output logic              beat,
    output logic              beat_we,
    output logic [ROW_W-1:0]  beat_row,
    output logic              done
);
    seq_state_t       state;
    logic [CNT_W-1:0] left;
    logic             dir_in;
    logic             req_ok;

    // Length in range and both length and start address row-aligned.
    always_comb begin
        req_ok = (req_len >= LEN_W'(MIN_BLK)) && (req_len <= LEN_W'(MAX_BLK))
              && (req_len[ROW_OFS-1:0] == '0) && (req_addr[ROW_OFS-1:0] == '0);
    end

    assign req_ready = (state == SEQ_IDLE);
    assign beat      = (state == SEQ_RUN);
    assign beat_we   = dir_in;

    // Accept or reject requests, then step through rows until none are left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            left     <= '0;
            dir_in   <= 1'b0;
            beat_row <= '0;
            req_err  <= 1'b0;
            done     <= 1'b0;
        end else begin
            req_err <= 1'b0;
            done    <= 1'b0;
            if (state == SEQ_IDLE) begin
                if (req_valid && req_ok) begin
                    state    <= SEQ_RUN;
                    left     <= req_len[LEN_W-1:ROW_OFS];
                    dir_in   <= req_to_store;
                    beat_row <= req_addr[ADDR_W-1:ROW_OFS];
                end else if (req_valid) begin
                    req_err <= 1'b1;
                end
            end else begin
                beat_row <= beat_row + 1'b1;
                left     <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    state <= SEQ_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    assert_reject_without_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!beat && req_ready));
    assert_done_after_last_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(beat) && !beat));
    assert_beats_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && left > CNT_W'(1)) |=> beat);
endmodule

// File: rtl/spad_local_store.sv
// Scratchpad local store top. A 128-bit core port and a 1024-bit transfer port
// share one row-organised array. The block sequencer drives the transfer port
// and always has priority. Misaligned core addresses are flagged and dropped.
// Assumes SIZE_BYTES is a power of two and at least one row.
module spad_local_store
    import spad_pkg::*;
#(
    parameter int SIZE_BYTES = 262144,
    parameter int LEN_W      = 15,
    parameter int MIN_BLK    = 1024,
    parameter int MAX_BLK    = 16384,
    localparam int ADDR_W    = $clog2(SIZE_BYTES),
    localparam int ROWS      = SIZE_BYTES / (WIDE_W / 8),
    localparam int ROW_W     = ADDR_W - ROW_OFS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_valid,
    output logic                core_ready,
    input  logic                core_we,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [NARROW_W-1:0] core_wdata,
    output logic                core_rvalid,
    output logic [NARROW_W-1:0] core_rdata,
    output logic                core_err,
    input  logic                blk_valid,
    output logic                blk_ready,
    input  logic                blk_to_store,
    input  logic [ADDR_W-1:0]   blk_addr,
    input  logic [LEN_W-1:0]    blk_len,
    output logic                blk_err,
    output logic                blk_done,
    output logic                xfer_beat,
    input  logic [WIDE_W-1:0]   xfer_wdata,
    output logic                xfer_rvalid,
    output logic [WIDE_W-1:0]   xfer_rdata
);
    logic                  beat_we;
    logic [ROW_W-1:0]      beat_row;
    logic                  core_aligned;
    logic                  core_grant;
    logic                  arr_en;
    logic [LANES-1:0]      arr_lane_we;
    logic [ROW_W-1:0]      arr_row;
    logic [WIDE_W-1:0]     arr_wdata;
    logic [WIDE_W-1:0]     arr_rdata;
    logic                  core_lane_rd;
    logic [LANE_SEL_W-1:0] core_lane_q;

    spad_block_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(blk_valid), .req_to_store(blk_to_store),
        .req_addr(blk_addr), .req_len(blk_len),
        .req_ready(blk_ready), .req_err(blk_err),
        .beat(xfer_beat), .beat_we(beat_we), .beat_row(beat_row),
        .done(blk_done)
    );

    assign core_aligned = (core_addr[LANE_OFS-1:0] == '0);
    assign core_ready   = !xfer_beat;

    spad_port_arbiter #(.ROW_W(ROW_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .xfer_req(xfer_beat), .xfer_we(beat_we),
        .xfer_row(beat_row), .xfer_wdata(xfer_wdata),
        .core_req(core_valid && core_aligned), .core_we(core_we),
        .core_row(core_addr[ADDR_W-1:ROW_OFS]),
        .core_lane(core_addr[ROW_OFS-1:LANE_OFS]),
        .core_wdata(core_wdata),
        .core_grant(core_grant),
        .arr_en(arr_en), .arr_lane_we(arr_lane_we),
        .arr_row(arr_row), .arr_wdata(arr_wdata),
        .xfer_rd_q(xfer_rvalid), .core_rd_q(core_lane_rd),
        .core_lane_q(core_lane_q)
    );

    spad_store_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
        .clk(clk), .en(arr_en), .lane_we(arr_lane_we),
        .row(arr_row), .wdata(arr_wdata), .rdata(arr_rdata)
    );

    // Flag an accepted core access whose address is not lane-aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) core_err <= 1'b0;
        else        core_err <= core_valid && core_ready && !core_aligned;
    end

    assign core_rvalid = core_lane_rd;
    assign core_rdata  = arr_rdata[core_lane_q*NARROW_W +: NARROW_W];
    assign xfer_rdata  = arr_rdata;

    assert_err_has_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_err |-> !core_rvalid);
    assert_core_data_after_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_rvalid |-> $past(core_valid && !core_we && !xfer_beat));
    assert_row_data_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rvalid |-> $past(xfer_beat && !blk_done && !beat_we));
    assert_beat_blocks_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_beat |-> !core_grant);
endmodule

// File: tb/spad_local_store_test.sv
`timescale 1ns/1ps
module spad_local_store_test;
    localparam int SIZE   = 8192;
    localparam int ROWS   = SIZE / 128;
    localparam int ADDR_W = $clog2(SIZE);
    localparam int LEN_W  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              core_valid = 0, core_we = 0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic [127:0]      core_wdata = '0;
    logic              core_ready, core_rvalid, core_err;
    logic [127:0]      core_rdata;
    logic              blk_valid = 0, blk_to_store = 0;
    logic [ADDR_W-1:0] blk_addr = '0;
    logic [LEN_W-1:0]  blk_len = '0;
    logic              blk_ready, blk_err, blk_done, xfer_beat, xfer_rvalid;
    logic [1023:0]     xfer_wdata = '0;
    logic [1023:0]     xfer_rdata;

    spad_local_store #(.SIZE_BYTES(SIZE), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_ready(core_ready), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rvalid(core_rvalid), .core_rdata(core_rdata), .core_err(core_err),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_to_store(blk_to_store),
        .blk_addr(blk_addr), .blk_len(blk_len), .blk_err(blk_err),
        .blk_done(blk_done), .xfer_beat(xfer_beat), .xfer_wdata(xfer_wdata),
        .xfer_rvalid(xfer_rvalid), .xfer_rdata(xfer_rdata)
    );

    int total = 0;
    int bad = 0;
    logic [1023:0] shadow [ROWS];
    logic [127:0]  core_q [$];
    logic [1023:0] row_q  [$];

    task automatic check(input bit ok, input string tag, input logic [1023:0] act,
                         input logic [1023:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1023:0] pat(input int seed, input int beat);
        logic [1023:0] v;
        for (int l = 0; l < 8; l++)
            v[l*128 +: 128] = {32'(seed), 32'(beat), 32'(l), 32'hC0DE_0000 + 32'(l)};
        return v;
    endfunction

    // Scoreboard monitor: compare returning core and row data in order.
    always @(negedge clk) begin
        if (rst_n && core_rvalid) begin
            if (core_q.size() == 0) check(1'b0, "R1 unexpected core_rvalid", 1, 0);
            else begin
                logic [127:0] e;
                e = core_q.pop_front();
                check(core_rdata == e, "R1 core read data", core_rdata, e);
            end
        end
        if (rst_n && xfer_rvalid) begin
            if (row_q.size() == 0) check(1'b0, "R6 unexpected xfer_rvalid", 1, 0);
            else begin
                logic [1023:0] e;
                e = row_q.pop_front();
                check(xfer_rdata == e, "R6 row read data", xfer_rdata, e);
            end
        end
    end

    // Driver for one core access; waits out stalls, updates model on acceptance.
    task automatic core_op(input bit we, input int addr, input logic [127:0] d);
        @(negedge clk);
        core_valid = 1; core_we = we; core_addr = ADDR_W'(addr); core_wdata = d;
        while (!core_ready) @(negedge clk);
        if (addr[3:0] == 0) begin
            int r, l;
            r = (addr / 128) % ROWS; l = (addr / 16) % 8;
            if (we) shadow[r][l*128 +: 128] = d;
            else core_q.push_back(shadow[r][l*128 +: 128]);
        end
        @(negedge clk);
        core_valid = 0;
        if (addr[3:0] != 0) check(core_err == 1'b1, "R2 core_err raised", core_err, 1);
        else check(core_err == 1'b0, "R2 no core_err on aligned", core_err, 0);
    endtask

    // Driver for one block request; supplies beat data and checks beat count and done.
    task automatic blk_op(input int addr, input int len, input bit to_store, input int seed);
        bit ok;
        int k, r;
        bit ready_seen_high;
        ok = (len >= 1024) && (len <= 16384) && (len % 128 == 0) && (addr % 128 == 0);
        @(negedge clk);
        blk_valid = 1; blk_addr = ADDR_W'(addr); blk_len = LEN_W'(len); blk_to_store = to_store;
        @(negedge clk);
        blk_valid = 0;
        if (!ok) begin
            check(blk_err == 1'b1, "R3 blk_err on bad request", blk_err, 1);
            check(xfer_beat == 1'b0 && blk_ready == 1'b1, "R3 no beat after reject",
                  xfer_beat, 0);
            @(negedge clk);
            check(xfer_beat == 1'b0, "R3 still no beat", xfer_beat, 0);
            return;
        end
        k = 0; ready_seen_high = 0;
        while (xfer_beat) begin
            if (core_ready || blk_ready) ready_seen_high = 1;
            r = (addr / 128 + k) % ROWS;
            if (to_store) begin
                xfer_wdata = pat(seed, k);
                shadow[r] = xfer_wdata;
            end else begin
                row_q.push_back(shadow[r]);
            end
            k++;
            @(negedge clk);
        end
        check(!ready_seen_high, "R8 core_ready and blk_ready low in beat cycles",
              ready_seen_high, 0);
        check(k == len / 128, "R4 beat count", k, len / 128);
        check(blk_done == 1'b1 && blk_ready == 1'b1, "R7 done pulse after last beat",
              {blk_done, blk_ready}, 2'b11);
        @(negedge clk);
        check(blk_done == 1'b0, "R7 done lasts one cycle", blk_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        check(blk_ready && core_ready && !core_rvalid && !core_err && !blk_done
              && !blk_err && !xfer_beat && !xfer_rvalid, "R7 reset state",
              {blk_ready, core_ready, core_rvalid, core_err, blk_done}, 5'b11000);

        // R1: lane writes and reads, two lanes of one row plus another row
        core_op(1, 'h0100, 128'h1111);
        core_op(1, 'h0130, 128'h3333);
        core_op(1, 'h1F70, 128'h7777);
        core_op(0, 'h0100, '0);
        core_op(0, 'h0130, '0);
        core_op(0, 'h1F70, '0);
        core_op(1, 'h0110, 128'hAAAA);
        core_op(0, 'h0100, '0);
        core_op(0, 'h0110, '0);

        // R2: misaligned store and load do nothing
        core_op(1, 'h0104, 128'hDEAD);
        core_op(0, 'h0109, '0);
        core_op(0, 'h0100, '0);

        // R3: rejected requests at each limit
        blk_op('h0000, 896, 1, 1);
        blk_op('h0000, 16512, 1, 1);
        blk_op('h0000, 1000, 1, 1);
        blk_op('h0040, 1024, 1, 1);

        // R4, R5, R7: inbound block at the minimum length
        blk_op('h0400, 1024, 1, 2);
        core_op(0, 'h0400, '0);
        core_op(0, 'h07F0, '0);

        // R6: outbound block wrapping at the top of the store
        blk_op('h1E00, 1024, 0, 0);

        // R8: load held across an inbound block returns the new row
        fork
            blk_op('h0800, 1024, 1, 3);
            begin
                repeat (3) @(negedge clk);
                core_op(0, 'h0BB0, '0);
            end
        join

        // R4: maximum length wraps twice; second pass must win
        blk_op('h1000, 16384, 1, 4);
        core_op(0, 'h1000, '0);
        core_op(0, 'h0050, '0);
        blk_op('h0000, 2048, 0, 0);

        repeat (4) @(negedge clk);
        check(core_q.size() == 0 && row_q.size() == 0, "R1 all expected reads returned",
              core_q.size() + row_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule